// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation table held in ordinary memory. A request is taken over a valid/ready stream while the walker is idle. The walker first fetches the directory entry selected by the top ten address bits. If that entry describes a 4 MB large page and large pages are enabled, the walk ends there. Otherwise it fetches the table entry selected by the next ten bits and forms a 4 KB page address. All memory traffic goes through one word-wide port with a request/acknowledge handshake, and only one access is in flight at a time.

The walker checks presence, user access and write permission against the current privilege level, an override flag and a write-protect enable. After a successful walk it writes the accessed and dirty marks back into the entries it used. A failed walk latches the faulting address and an error code, and raises a sticky pending flag. While that flag is set, each new request fails at once, until the flag is cleared. In probe mode the walker returns only success or failure. It then updates no fault state and writes nothing back.

The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take it in that cycle. `req_ready` is high only while the walker is idle. A request is accepted on any clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk is at address {dir_frame, linear[31:22], 2'b00}.
- R2: When the directory entry is present and is not taken as a large page, the second read is at {directory_entry[31:12], linear[21:12], 2'b00}.
- R3: A directory entry with bit 7 set, while large_en is high, ends the walk. On success the physical address is {directory_entry[31:22], linear[21:0]}.
- R4: For a 4 KB page the physical address on success is {table_entry[31:12], linear[11:0]}. The write permission (bit 1) and user permission (bit 2) checked are the AND of the directory and table entry bits.
- R5: A walk fails in three cases:
  - the entry it reached has bit 0 (present) clear;
  - cpl is 3, cpl_override is low and the user permission is clear;
  - it is a write, the write permission is clear, and either wp_en is high or (cpl is 3 and cpl_override is low).
- R6: A failure outside probe mode makes three updates. It latches the linear address into fault_addr. It sets fault_code to {cpl==3, write, present bit of the failing entry}, where bit 0 is the present bit. It sets fault_pending.
- R7: A successful 4 KB walk outside probe mode does two write-backs. The directory entry is written back ORed with 0x20. The table entry is written back ORed with 0x20 on a read and with 0x60 on a write.
- R8: A successful large-page walk outside probe mode writes the directory entry back ORed with 0x20 on a read and with 0x60 on a write. It leaves the table entry untouched.
- R9: In probe mode the walker performs no memory write. It leaves fault_addr, fault_code and fault_pending unchanged.
- R10: While fault_pending is high, an accepted request returns a failure with no memory access. A fault_clr pulse clears fault_pending.
- R11: On success rsp_user equals bit 2 of the final entry: the directory entry for a large page, the table entry otherwise.
- R12: Once mem_req is raised, it stays high with stable address and direction until mem_ack. The accesses follow the order directory read, table read, directory write-back, table write-back, skipping the ones not needed.
- R13: rsp_valid is high for exactly one cycle per accepted request. req_ready is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_frame | input | 20 | Page frame of the directory (base bits 31:12) |
| large_en | input | 1 | Enables 4 MB directory-level pages |
| wp_en | input | 1 | Applies write permission at every privilege level |
| cpl | input | 2 | Current privilege level |
| cpl_override | input | 1 | Treats a level-3 access as privileged for the checks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_probe | input | 1 | Probe only: no write-back, no fault state |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Walk failed |
| rsp_paddr | output | 32 | Physical address on success |
| rsp_user | output | 1 | User permission of the final entry |
| fault_pending | output | 1 | Sticky fault flag |
| fault_addr | output | 32 | Linear address of the last fault |
| fault_code | output | 3 | Error code of the last fault |
| fault_clr | input | 1 | Clears fault_pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the walker with the default ten-bit index width, so the full 32-bit entry format is in use. Its memory model decodes only fourteen address bits. This leaves the high frame bits of the directory base and of the entries free to carry arbitrary patterns. The bench sweeps all 8192 combinations of these inputs:
- the present, write and user bits of both entries;
- the large-page bit;
- privilege level 3 or not, override, write, write-protect, large-page enable and probe.

Expected addresses, permissions, error codes and written-back entries are all computed arithmetically in the bench. After every non-probe fault, the bench also exercises the pending-fault path and the fault_clr path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int IDX_W_DEF = 10;

  localparam int F_PRES  = 0;
  localparam int F_WR    = 1;
  localparam int F_USR   = 2;
  localparam int F_ACC   = 5;
  localparam int F_DIRTY = 6;
  localparam int F_LARGE = 7;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DIR,
    S_RD_TBL,
    S_WB_DIR,
    S_WB_TBL,
    S_RESP
  } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W = 10,
  localparam int FRM_W = 2 * IDX_W,
  localparam int LIN_W = 3 * IDX_W + 2
) (
  input  logic [FRM_W-1:0] dir_frame,
  input  logic [FRM_W-1:0] pde_frame,
  input  logic [IDX_W-1:0] dir_idx,
  input  logic [IDX_W-1:0] tbl_idx,
  output logic [LIN_W-1:0] pde_addr,
  output logic [LIN_W-1:0] pte_addr
);
  // Four-byte entries: the index is scaled by two zero bits.
  assign pde_addr = {dir_frame, dir_idx, 2'b00};
  assign pte_addr = {pde_frame, tbl_idx, 2'b00};
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic              present,
  input  logic              writable,
  input  logic              user_ok,
  input  logic              is_write,
  input  logic              cpl3,
  input  logic              override,
  input  logic              wp_en,
  output logic              fault,
  output logic [CODE_W-1:0] code
);
  logic user_mode;
  logic deny_user;
  logic deny_write;

  assign user_mode  = cpl3 && !override;
  assign deny_user  = user_mode && !user_ok;
  assign deny_write = is_write && !writable && (wp_en || user_mode);
  assign fault      = !present || deny_user || deny_write;
  assign code       = {cpl3, is_write, present};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W = IDX_W_DEF,
  localparam int FRM_W = 2 * IDX_W,
  localparam int OFS_W = IDX_W + 2,
  localparam int LIN_W = 3 * IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRM_W-1:0]  dir_frame,
  input  logic              large_en,
  input  logic              wp_en,
  input  logic [1:0]        cpl,
  input  logic              cpl_override,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LIN_W-1:0]  req_addr,
  input  logic              req_write,
  input  logic              req_probe,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [LIN_W-1:0]  rsp_paddr,
  output logic              rsp_user,
  output logic              fault_pending,
  output logic [LIN_W-1:0]  fault_addr,
  output logic [CODE_W-1:0] fault_code,
  input  logic              fault_clr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LIN_W-1:0]  mem_addr,
  output logic [LIN_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [LIN_W-1:0]  mem_rdata
);
  localparam int LG_OFS_W = OFS_W + IDX_W;
  localparam logic [LIN_W-1:0] ACC_M   = LIN_W'(1) << F_ACC;
  localparam logic [LIN_W-1:0] DIRTY_M = LIN_W'(1) << F_DIRTY;

  walk_state_t state;

  logic [LIN_W-1:0]  lin_q;
  logic              wr_q, probe_q, cpl3_q, ovr_q, wp_q, lgen_q;
  logic [LIN_W-1:0]  pde_q, pte_q;
  logic              large_q;
  logic              rsp_fault_q, rsp_user_q;
  logic [LIN_W-1:0]  rsp_paddr_q;
  logic [LIN_W-1:0]  flt_addr_q;
  logic [CODE_W-1:0] flt_code_q;
  logic              pend_q;

  logic [LIN_W-1:0]  pde_addr, pte_addr;
  logic              dir_large;
  logic              chk_wr, chk_usr, chk_fault;
  logic [CODE_W-1:0] chk_code;
  logic [LIN_W-1:0]  dir_wb, tbl_wb;
  logic [LIN_W-1:0]  large_pa, small_pa;

  ptw_addr_gen #(.IDX_W(IDX_W)) u_addr (
    .dir_frame (dir_frame),
    .pde_frame (pde_q[LIN_W-1:OFS_W]),
    .dir_idx   (lin_q[LIN_W-1 -: IDX_W]),
    .tbl_idx   (lin_q[LG_OFS_W-1 -: IDX_W]),
    .pde_addr  (pde_addr),
    .pte_addr  (pte_addr)
  );

  assign dir_large = mem_rdata[F_LARGE] && lgen_q;

  // Directory stage of a 4 KB walk only checks presence; the table stage
  // checks the combined permissions of both levels.
  always_comb begin
    if (state == S_RD_TBL) begin
      chk_wr  = pde_q[F_WR] & mem_rdata[F_WR];
      chk_usr = pde_q[F_USR] & mem_rdata[F_USR];
    end else if (dir_large) begin
      chk_wr  = mem_rdata[F_WR];
      chk_usr = mem_rdata[F_USR];
    end else begin
      chk_wr  = 1'b1;
      chk_usr = 1'b1;
    end
  end

  ptw_perm_check u_perm (
    .present  (mem_rdata[F_PRES]),
    .writable (chk_wr),
    .user_ok  (chk_usr),
    .is_write (wr_q),
    .cpl3     (cpl3_q),
    .override (ovr_q),
    .wp_en    (wp_q),
    .fault    (chk_fault),
    .code     (chk_code)
  );

  assign large_pa = {mem_rdata[LIN_W-1 -: IDX_W], lin_q[LG_OFS_W-1:0]};
  assign small_pa = {mem_rdata[LIN_W-1:OFS_W], lin_q[OFS_W-1:0]};
  assign dir_wb   = pde_q | ACC_M | ((large_q && wr_q) ? DIRTY_M : '0);
  assign tbl_wb   = pte_q | ACC_M | (wr_q ? DIRTY_M : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lin_q       <= '0;
      wr_q        <= 1'b0;
      probe_q     <= 1'b0;
      cpl3_q      <= 1'b0;
      ovr_q       <= 1'b0;
      wp_q        <= 1'b0;
      lgen_q      <= 1'b0;
      pde_q       <= '0;
      pte_q       <= '0;
      large_q     <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_user_q  <= 1'b0;
      rsp_paddr_q <= '0;
      flt_addr_q  <= '0;
      flt_code_q  <= '0;
      pend_q      <= 1'b0;
    end else begin
      if (fault_clr) pend_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            lin_q       <= req_addr;
            wr_q        <= req_write;
            probe_q     <= req_probe;
            cpl3_q      <= (cpl == 2'b11);
            ovr_q       <= cpl_override;
            wp_q        <= wp_en;
            lgen_q      <= large_en;
            rsp_user_q  <= 1'b0;
            rsp_paddr_q <= '0;
            rsp_fault_q <= pend_q;
            state       <= pend_q ? S_RESP : S_RD_DIR;
          end
        end
        S_RD_DIR: begin
          if (mem_ack) begin
            pde_q   <= mem_rdata;
            large_q <= dir_large;
            if (chk_fault) begin
              rsp_fault_q <= 1'b1;
              state       <= S_RESP;
              if (!probe_q) begin
                flt_addr_q <= lin_q;
                flt_code_q <= chk_code;
                pend_q     <= 1'b1;
              end
            end else if (dir_large) begin
              rsp_paddr_q <= large_pa;
              rsp_user_q  <= mem_rdata[F_USR];
              state       <= probe_q ? S_RESP : S_WB_DIR;
            end else begin
              state <= S_RD_TBL;
            end
          end
        end
        S_RD_TBL: begin
          if (mem_ack) begin
            pte_q <= mem_rdata;
            if (chk_fault) begin
              rsp_fault_q <= 1'b1;
              state       <= S_RESP;
              if (!probe_q) begin
                flt_addr_q <= lin_q;
                flt_code_q <= chk_code;
                pend_q     <= 1'b1;
              end
            end else begin
              rsp_paddr_q <= small_pa;
              rsp_user_q  <= mem_rdata[F_USR];
              state       <= probe_q ? S_RESP : S_WB_DIR;
            end
          end
        end
        S_WB_DIR: if (mem_ack) state <= large_q ? S_RESP : S_WB_TBL;
        S_WB_TBL: if (mem_ack) state <= S_RESP;
        S_RESP:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_RD_TBL, S_WB_TBL: mem_addr = pte_addr;
      default:            mem_addr = pde_addr;
    endcase
  end

  assign mem_req   = (state == S_RD_DIR) || (state == S_RD_TBL) ||
                     (state == S_WB_DIR) || (state == S_WB_TBL);
  assign mem_we    = (state == S_WB_DIR) || (state == S_WB_TBL);
  assign mem_wdata = (state == S_WB_TBL) ? tbl_wb : dir_wb;

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_fault     = rsp_fault_q;
  assign rsp_paddr     = rsp_paddr_q;
  assign rsp_user      = rsp_user_q;
  assign fault_pending = pend_q;
  assign fault_addr    = flt_addr_q;
  assign fault_code    = flt_code_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          fault_pending,
  input logic [AW-1:0] fault_addr,
  input logic          probe_q
);
  // R12: an idle walker drives no memory access
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R12: a raised request holds address and direction until acknowledged
  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R13: the completion pulse lasts one cycle
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: a request taken while a fault is pending fails at once
  a_r10_pending_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fault_pending) |=> (rsp_valid && rsp_fault && !mem_req));

  // R9: a probe walk never writes memory
  a_r9_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !probe_q);

  // R6: the fault address moves only together with a failing response
  a_r6_fault_addr_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (rsp_valid && rsp_fault));
endmodule

bind ptw_walker ptw_walker_chk #(.AW(LIN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .fault_pending (fault_pending),
  .fault_addr    (fault_addr),
  .probe_q       (probe_q)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int CLK_NS = 10;
  localparam int IW = 10;
  localparam int FW = 2 * IW;
  localparam int LW = 3 * IW + 2;
  localparam int N_ITER = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] dir_frame = '0;
  logic          large_en = 1'b0, wp_en = 1'b0, cpl_override = 1'b0;
  logic [1:0]    cpl = 2'b00;
  logic          req_valid = 1'b0, req_write = 1'b0, req_probe = 1'b0;
  logic [LW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_fault, rsp_user, fault_pending;
  logic [LW-1:0] rsp_paddr, fault_addr;
  logic [2:0]    fault_code;
  logic          fault_clr = 1'b0;
  logic          mem_req, mem_we;
  logic [LW-1:0] mem_addr, mem_wdata;
  logic          mem_ack;
  logic [LW-1:0] mem_rdata;

  ptw_walker #(.IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .dir_frame(dir_frame), .large_en(large_en),
    .wp_en(wp_en), .cpl(cpl), .cpl_override(cpl_override),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_probe(req_probe),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_user(rsp_user), .fault_pending(fault_pending), .fault_addr(fault_addr),
    .fault_code(fault_code), .fault_clr(fault_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // Memory model: 16 KB decoded by address bits 13:2, one-cycle acknowledge.
  logic [31:0] mem [0:4095];
  logic        set_we = 1'b0;
  logic [11:0] set_ia = '0, set_ib = '0;
  logic [31:0] set_da = '0, set_db = '0;
  int          acc_cnt;
  logic [31:0] log_a [0:7];
  logic        log_w [0:7];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      acc_cnt <= 0;
    end else begin
      if (set_we) begin
        mem[set_ia] <= set_da;
        mem[set_ib] <= set_db;
      end
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[13:2]];
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        log_a[acc_cnt[2:0]] <= mem_addr;
        log_w[acc_cnt[2:0]] <= mem_we;
        acc_cnt <= acc_cnt + 1;
      end
    end
  end

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] a, input bit w, input bit p,
                         output bit got, output int base);
    @(negedge clk);
    set_we    = 1'b0;
    base      = acc_cnt;
    req_addr  = a;
    req_write = w;
    req_probe = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 100 && !got; k++) begin
      if (rsp_valid) got = 1'b1;
      else @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] prev_fa;
    prev_fa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R13 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R13 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req === 1'b0, "R12 reset mem_req", 32'(mem_req), 32'd0);
    chk(fault_pending === 1'b0, "R6 reset pending", 32'(fault_pending), 32'd0);

    for (int it = 0; it < N_ITER; it++) begin
      logic [31:0] h, h2, lin, pde, pte, pde_a, pte_a, e_pa, e_pde, e_pte;
      logic [2:0]  e_code;
      bit pP, pW, pU, pS, tP, tW, tU, c3, ov, wr, wp, lg, prb;
      bit lrg, ublk, ef, ep, eu, ew, e_user, got, got2;
      int base, base2, n_rd, n_wr, ix;

      pP = it[0];  pW = it[1];  pU = it[2];  pS = it[3];
      tP = it[4];  tW = it[5];  tU = it[6];  c3 = it[7];
      ov = it[8];  wr = it[9];  wp = it[10]; lg = it[11]; prb = it[12];
      h  = 32'(it) * 32'h9E3779B1;
      h2 = 32'(it) * 32'h85EBCA6B + 32'h1234567;
      lin = h;
      pde = {h2[31:14], 2'b10, h[7:4], pS, h2[1:0], h[1:0], pU, pW, pP};
      pte = {h2[21:2], h[12:4], tU, tW, tP};

      // Expected behaviour from the requirements.
      lrg  = pS && lg;
      ublk = c3 && !ov;
      eu = 1'b1; ew = 1'b1;
      if (!pP) begin
        ef = 1'b1; ep = 1'b0;
      end else if (lrg) begin
        eu = pU; ew = pW; ep = 1'b1;
        ef = (ublk && !eu) || (wr && !ew && (wp || ublk));
      end else if (!tP) begin
        ef = 1'b1; ep = 1'b0;
      end else begin
        eu = pU && tU; ew = pW && tW; ep = 1'b1;
        ef = (ublk && !eu) || (wr && !ew && (wp || ublk));
      end
      e_code = {c3, wr, ep};
      n_rd   = (!pP || lrg) ? 1 : 2;
      n_wr   = (ef || prb) ? 0 : (lrg ? 1 : 2);
      pde_a  = ({12'h000, h2[21:2], 2'b01} << 12) + ((lin >> 20) & 32'hFFC);
      pte_a  = (pde & 32'hFFFF_F000) + ((lin >> 10) & 32'hFFC);
      if (lrg) begin
        e_pa   = (pde & 32'hFFC0_0000) + (lin & 32'h003F_FFFF);
        e_user = pde[2];
      end else begin
        e_pa   = (pte & 32'hFFFF_F000) + (lin & 32'h0000_0FFF);
        e_user = pte[2];
      end
      e_pde = (!ef && !prb) ? (pde | 32'h20 | ((lrg && wr) ? 32'h40 : 32'h0)) : pde;
      e_pte = (!ef && !prb && !lrg) ? (pte | 32'h20 | (wr ? 32'h40 : 32'h0)) : pte;

      // Place the two entries and set the controls.
      @(negedge clk);
      dir_frame    = {h2[21:2], 2'b01} ;
      large_en     = lg;
      wp_en        = wp;
      cpl          = c3 ? 2'b11 : 2'(it % 3);
      cpl_override = ov;
      set_ia = pde_a[13:2]; set_da = pde;
      set_ib = pte_a[13:2]; set_db = pte;
      set_we = 1'b1;

      run_req(lin, wr, prb, got, base);
      chk(got, "R13 response arrives", 32'(got), 32'd1);
      chk(rsp_fault === ef, "R5 fault decision", 32'(rsp_fault), 32'(ef));
      if (!ef) begin
        chk(rsp_paddr === e_pa, lrg ? "R3 large page address" : "R4 small page address",
            rsp_paddr, e_pa);
        chk(rsp_user === e_user, "R11 user flag", 32'(rsp_user), 32'(e_user));
      end
      chk(acc_cnt - base == n_rd + n_wr, "R12 access count",
          32'(acc_cnt - base), 32'(n_rd + n_wr));
      ix = base & 7;
      chk(log_a[ix] === pde_a, "R1 directory read address", log_a[ix], pde_a);
      if (n_rd == 2) begin
        ix = (base + 1) & 7;
        chk(log_a[ix] === pte_a, "R2 table read address", log_a[ix], pte_a);
      end
      if (n_wr >= 1) begin
        ix = (base + n_rd) & 7;
        chk(log_w[ix] === 1'b1 && log_a[ix] === pde_a, "R12 directory write-back order",
            log_a[ix], pde_a);
      end
      if (n_wr == 2) begin
        ix = (base + n_rd + 1) & 7;
        chk(log_w[ix] === 1'b1 && log_a[ix] === pte_a, "R12 table write-back order",
            log_a[ix], pte_a);
      end

      @(negedge clk);
      chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R13 pulse ends, ready again",
          {30'd0, rsp_valid, req_ready}, 32'd1);

      chk(mem[pde_a[13:2]] === e_pde,
          prb ? "R9 directory entry" : (lrg ? "R8 directory entry" : "R7 directory entry"),
          mem[pde_a[13:2]], e_pde);
      chk(mem[pte_a[13:2]] === e_pte,
          prb ? "R9 table entry" : (lrg ? "R8 table entry" : "R7 table entry"),
          mem[pte_a[13:2]], e_pte);

      if (ef && prb) begin
        chk(fault_pending === 1'b0, "R9 probe leaves pending clear",
            32'(fault_pending), 32'd0);
        chk(fault_addr === prev_fa, "R9 probe leaves fault address", fault_addr, prev_fa);
      end
      if (ef && !prb) begin
        chk(fault_addr === lin, "R6 fault address", fault_addr, lin);
        chk(fault_code === e_code, "R6 fault code", 32'(fault_code), 32'(e_code));
        chk(fault_pending === 1'b1, "R6 pending set", 32'(fault_pending), 32'd1);
        prev_fa = lin;
        run_req(lin ^ 32'h0040_1000, it[1], it[2], got2, base2);
        chk(got2 && rsp_fault === 1'b1, "R10 pending request fails",
            32'(rsp_fault), 32'd1);
        chk(acc_cnt == base2, "R10 no memory access while pending",
            32'(acc_cnt - base2), 32'd0);
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk(fault_pending === 1'b0, "R10 clear drops pending", 32'(fault_pending), 32'd0);
        chk(fault_addr === prev_fa, "R10 clear keeps fault address", fault_addr, prev_fa);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule